// File: doc/BRIEF.md
# Three-Button Kitchen Timer Controller

This block is the control core of a kitchen timer. It watches three set/start buttons, keeps a set time as minutes and seconds, and runs in one of three modes: idle, counting up, or counting down. The time is advanced or reduced by a one-cycle seconds strobe, which comes from a divider outside the block. The block drives the minutes and seconds for a display and an enable for a buzzer.

The buttons are level inputs that are already debounced and synchronous to the clock. Only the cycle in which a button goes from low to high counts as an action. A START/STOP action with the time at zero turns the timer into a stopwatch that counts up. With a nonzero time, the same action starts a countdown. Pressing both set buttons together clears the timer. Any action while the timer runs stops it.

Top module: `kitchen_timer`

## Requirements
- R1: After synchronous reset the time reads 00:00, the mode is idle and the buzzer output is low.
- R2: A button action is a rising edge: the input is high this cycle and was low the cycle before. Holding a button high for further cycles has no additional effect.
- R3: A minutes action and a seconds action in the same cycle set the time to 00:00 and the mode to idle. This overrides every other action in that cycle, including START/STOP and a stop while running.
- R4: A minutes action alone, while idle, adds one minute. Minutes saturate at MAX_MIN. A minutes action that would pass MAX_MIN:59 leaves the time at MAX_MIN:59.
- R5: A seconds action alone, while idle, adds one second. Seconds wrap from 59 to 0 and carry into minutes. The time saturates at MAX_MIN:59. The seconds output never exceeds 59.
- R6: A START/STOP action while idle with the time at 00:00 enters count-up mode. Each tick then adds one second, up to MAX_MIN:59, where the time holds.
- R7: A START/STOP action while idle with a nonzero time enters count-down mode. Each tick then subtracts one second. When the time reaches 00:00, the mode returns to idle and the time stays at zero.
- R8: While counting, an action on any button returns the mode to idle and leaves the time unchanged, even if a tick arrives in the same cycle.
- R9: A START/STOP action together with a single set-button action while idle applies the increment first. The count direction is then chosen from the incremented time.
- R10: Every button action, and every countdown that reaches zero, drives the buzzer high for exactly BUZZ_CYCLES clock cycles, starting the cycle after the event. A new event restarts that window.
- R11: Ticks while idle leave the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_min | input | 1 | Minutes button level, active high |
| btn_sec | input | 1 | Seconds button level, active high |
| btn_go | input | 1 | START/STOP button level, active high |
| tick | input | 1 | One-cycle seconds strobe |
| minutes | output | $clog2(MAX_MIN+1) | Current minutes |
| seconds | output | 6 | Current seconds, 0 to 59 |
| buzzer | output | 1 | Buzzer enable |

## Verification
Seconds actions are swept one at a time from zero past several minute boundaries, which separates a correct carry from a wrap that loses the minute. Minutes actions are swept up to and beyond saturation, which shows whether the time is clamped at the full maximum or only in the minutes field. Long tick trains are run in both count directions. Count-up is run all the way to the ceiling, and count-down is run to zero, which shows whether the mode really falls back to idle. Combined patterns are also applied: both set buttons, a set button with START/STOP, a press together with a tick while running, and a held level. Each of these tells priority and edge detection apart from plain level decoding. The buzzer window is measured cycle by cycle, both for a single event and for an event that restarts it.

// File: rtl/kitchen_timer.sv
module kitchen_timer #(
  parameter int MAX_MIN     = 99,
  parameter int BUZZ_CYCLES = 8,
  localparam int MIN_W = $clog2(MAX_MIN + 1),
  localparam int BZ_W  = $clog2(BUZZ_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_min,
  input  logic             btn_sec,
  input  logic             btn_go,
  input  logic             tick,
  output logic [MIN_W-1:0] minutes,
  output logic [5:0]       seconds,
  output logic             buzzer
);

  typedef enum logic [1:0] {IDLE, UP, DOWN} mode_t;

  localparam logic [MIN_W-1:0] MMAX = MIN_W'(MAX_MIN);
  localparam logic [5:0]       SMAX = 6'd59;

  mode_t            mode_q, mode_d;
  logic [2:0]       prev_q;
  logic [MIN_W-1:0] min_q, min_d;
  logic [5:0]       sec_q, sec_d;
  logic [BZ_W-1:0]  bz_q;
  logic             down_done;

  wire p_min = btn_min & ~prev_q[0];
  wire p_sec = btn_sec & ~prev_q[1];
  wire p_go  = btn_go  & ~prev_q[2];
  wire any_p = p_min | p_sec | p_go;
  wire clr   = p_min & p_sec;

  // one second forward, saturating at MAX:59
  logic [MIN_W-1:0] fw_min;
  logic [5:0]       fw_sec;
  always_comb begin
    if (sec_q != SMAX) begin
      fw_min = min_q;
      fw_sec = sec_q + 6'd1;
    end else if (min_q == MMAX) begin
      fw_min = MMAX;
      fw_sec = SMAX;
    end else begin
      fw_min = min_q + 1'b1;
      fw_sec = '0;
    end
  end

  // one minute forward, clamped to MAX:59
  wire [MIN_W-1:0] mf_min = (min_q == MMAX) ? MMAX : min_q + 1'b1;
  wire [5:0]       mf_sec = (min_q == MMAX) ? SMAX : sec_q;

  // one second back
  wire [MIN_W-1:0] bk_min = (sec_q == '0) ? min_q - 1'b1 : min_q;
  wire [5:0]       bk_sec = (sec_q == '0) ? SMAX : sec_q - 6'd1;

  // set result while idle
  logic [MIN_W-1:0] st_min;
  logic [5:0]       st_sec;
  always_comb begin
    st_min = min_q;
    st_sec = sec_q;
    if (p_min && !p_sec) begin
      st_min = mf_min;
      st_sec = mf_sec;
    end else if (p_sec && !p_min) begin
      st_min = fw_min;
      st_sec = fw_sec;
    end
  end

  always_comb begin
    mode_d    = mode_q;
    min_d     = min_q;
    sec_d     = sec_q;
    down_done = 1'b0;
    if (clr) begin
      mode_d = IDLE;
      min_d  = '0;
      sec_d  = '0;
    end else if (mode_q != IDLE) begin
      if (any_p) begin
        mode_d = IDLE;
      end else if (tick) begin
        if (mode_q == UP) begin
          min_d = fw_min;
          sec_d = fw_sec;
        end else begin
          min_d = bk_min;
          sec_d = bk_sec;
          if (bk_min == '0 && bk_sec == '0) begin
            mode_d    = IDLE;
            down_done = 1'b1;
          end
        end
      end
    end else begin
      min_d = st_min;
      sec_d = st_sec;
      if (p_go) mode_d = (st_min == '0 && st_sec == '0) ? UP : DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= IDLE;
      min_q  <= '0;
      sec_q  <= '0;
      prev_q <= '0;
      bz_q   <= '0;
    end else begin
      mode_q <= mode_d;
      min_q  <= min_d;
      sec_q  <= sec_d;
      prev_q <= {btn_go, btn_sec, btn_min};
      if (any_p || down_done) bz_q <= BZ_W'(BUZZ_CYCLES);
      else if (bz_q != '0)    bz_q <= bz_q - 1'b1;
    end
  end

  assign minutes = min_q;
  assign seconds = sec_q;
  assign buzzer  = (bz_q != '0);

  // R3
  clear_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_min && btn_sec && !$past(btn_min) && !$past(btn_sec))
      |=> (minutes == '0 && seconds == '0 && mode_q == IDLE));

  // R2 R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_p && (!tick || mode_q == IDLE)) |=> $stable({minutes, seconds}));

  // R8
  stop_keeps_time_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != IDLE && any_p && !(p_min && p_sec))
      |=> (mode_q == IDLE && $stable({minutes, seconds})));

  // R7
  down_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DOWN) |-> (minutes != '0 || seconds != '0));

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    seconds <= SMAX);

  // R10
  buzz_start_chk: assert property (@(posedge clk) disable iff (rst)
    any_p |=> buzzer);

endmodule

// File: tb/kitchen_timer_bench.sv
module kitchen_timer_bench;
  localparam int MAXM = 99;
  localparam int BZ   = 3;
  localparam int TOP  = MAXM * 60 + 59;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_min = 0, btn_sec = 0, btn_go = 0, tick = 0;
  logic [$clog2(MAXM+1)-1:0] minutes;
  logic [5:0] seconds;
  logic buzzer;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kitchen_timer #(.MAX_MIN(MAXM), .BUZZ_CYCLES(BZ)) u_kitchen_timer (
    .clk(clk), .rst(rst), .btn_min(btn_min), .btn_sec(btn_sec),
    .btn_go(btn_go), .tick(tick), .minutes(minutes), .seconds(seconds),
    .buzzer(buzzer));

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_t(int exp, string tag);
    n_chk++;
    if (int'(minutes) != exp / 60 || int'(seconds) != exp % 60) begin
      n_bad++;
      $display("FAIL %s: time %0d:%0d expected %0d:%0d", tag,
               minutes, seconds, exp / 60, exp % 60);
    end
  endtask

  task automatic chk_b(logic exp, string tag);
    n_chk++;
    if (buzzer !== exp) begin
      n_bad++;
      $display("FAIL %s: buzzer %b expected %b", tag, buzzer, exp);
    end
  endtask

  // mask bit0 min, bit1 sec, bit2 go
  task automatic press(logic [2:0] m);
    btn_min = m[0]; btn_sec = m[1]; btn_go = m[2];
    cyc();
    btn_min = 0; btn_sec = 0; btn_go = 0;
    cyc();
  endtask

  task automatic tk();
    tick = 1; cyc(); tick = 0; cyc();
  endtask

  // called one cycle after the event edge; checks the rest of the window
  task automatic buzz_tail(string tag);
    chk_b(1'b1, tag);
    for (int i = 1; i < BZ; i++) begin
      cyc();
      chk_b(1'b1, tag);
    end
    cyc();
    chk_b(1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1
    chk_t(0, "R1 reset time");
    chk_b(1'b0, "R1 reset buzzer");

    // R5 seconds sweep with carry
    for (int k = 1; k <= 130; k++) begin
      press(3'b010);
      chk_t(k, "R5 seconds step");
    end

    // R2 held level acts once
    btn_sec = 1;
    repeat (6) cyc();
    chk_t(131, "R2 held seconds");
    btn_sec = 0; cyc();

    // R11 idle ticks ignored
    repeat (5) tk();
    chk_t(131, "R11 idle ticks");

    // R3 clear
    press(3'b011);
    chk_t(0, "R3 clear idle");

    // R4 minutes sweep past saturation
    press(3'b010);
    for (int k = 1; k <= MAXM + 3; k++) begin
      press(3'b001);
      t = 1 + 60 * k;
      if (t > TOP) t = TOP;
      chk_t(t, "R4 minutes step");
    end
    press(3'b010);
    chk_t(TOP, "R5 seconds saturate");

    // R3 over START/STOP
    press(3'b111);
    chk_t(0, "R3 clear with go");
    tk();
    chk_t(0, "R3 stays idle");

    // R6 count up to the ceiling
    press(3'b100);
    for (int k = 1; k <= TOP + 4; k++) begin
      tk();
      if (k % 500 == 0 || k < 70 || k > TOP - 3)
        chk_t((k > TOP) ? TOP : k, "R6 count up");
    end

    // R8 stop by press with simultaneous tick, time unchanged
    press(3'b011);
    press(3'b100);
    repeat (10) tk();
    btn_sec = 1; tick = 1; cyc();
    btn_sec = 0; tick = 0; cyc();
    chk_t(10, "R8 stop keeps time");
    repeat (3) tk();
    chk_t(10, "R8 idle after stop");

    // R3 over stop while running
    press(3'b100);
    tk();
    press(3'b011);
    chk_t(0, "R3 clear while running");
    tk();
    chk_t(0, "R3 idle after running clear");

    // R7 count down to zero, buzzer on zero
    press(3'b001);
    press(3'b010);
    press(3'b100);
    repeat (5) cyc();
    for (int k = 1; k <= 60; k++) begin
      tk();
      chk_t(61 - k, "R7 count down");
    end
    tick = 1; cyc(); tick = 0;
    chk_t(0, "R7 reaches zero");
    buzz_tail("R10 zero alarm");
    repeat (3) tk();
    chk_t(0, "R7 idle at zero");
    chk_b(1'b0, "R10 no repeat alarm");

    // R9 go + sec at zero counts down from 1
    press(3'b110);
    chk_t(1, "R9 go with seconds");
    tk();
    chk_t(0, "R9 counted down");
    tk();
    chk_t(0, "R9 idle after zero");

    // R9 go + min at zero counts down from 60
    press(3'b101);
    chk_t(60, "R9 go with minutes");
    tk();
    chk_t(59, "R9 minute countdown");
    press(3'b100);
    tk();
    chk_t(59, "R8 stopped by go");

    // R10 single press window and restart
    repeat (5) cyc();
    chk_b(1'b0, "R10 quiet");
    btn_sec = 1; cyc(); btn_sec = 0;
    buzz_tail("R10 press window");
    btn_min = 1; cyc(); btn_min = 0;
    cyc();
    btn_sec = 1; cyc(); btn_sec = 0;
    buzz_tail("R10 restart window");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule